// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

A 32-line general-purpose I/O bank behind a word-wide register interface. Software programs each line as input or output, sets output levels, optionally inverts how an input is seen, and may hand an output over to one of two external blink waveforms. Inputs are brought into the clock domain by a two-stage synchronizer. The synchronized value is then XORed with the per-line inversion bit, and the result is what software reads as the input value.

The inversion-adjusted input feeds two interrupt sources. The first is a level source that uses the live adjusted value. The second is an edge source that latches a rising transition of the adjusted value into a sticky cause register. Each source has its own mask. The pending result per line is OR-reduced in groups of eight, giving one interrupt output per group. Software acknowledges an edge by writing the cause register with 0 in the bits to clear and 1 in the bits to keep.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF (all inputs) and every other register reads 0. `pin_oe` is 0 and `irq_grp` is 0.
- R2: Direction bit 0 makes a line an output (`pin_oe` bit 1). Direction bit 1 makes it an input (`pin_oe` bit 0). With blink disabled, an output line drives the output-data bit.
- R3: The input register (offset 0x10) returns the pin value, delayed by two clocks of synchronization, XORed with the polarity register (offset 0x0C). Writes to offset 0x10 have no effect.
- R4: A 0-to-1 transition of the polarity-adjusted input sets that line's bit in the cause register (offset 0x14). With polarity 0 this is a rising pin, and with polarity 1 a falling pin. Flipping polarity on a steady line also counts. The bit is visible three clocks after the pin changes.
- R5: A write to the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged. Without a write, set bits stay set.
- R6: An edge arriving in the same cycle as a clear of the same bit wins, and the bit stays set.
- R7: A line's pending value is (adjusted input AND level mask at 0x1C) OR (cause AND edge mask at 0x18). The level term follows the input with no latching.
- R8: `irq_grp[g]` is the OR of the pending values of lines 8g to 8g+7.
- R9: When the blink-enable bit (0x08) of a line is set, the pin drives `blink_b` if the line's counter-select bit (0x20) is 1 and `blink_a` if it is 0, in place of the output-data bit (0x00).
- R10: The readable and writable registers at offsets 0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C and 0x20 return the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | 32 | Raw pad input levels |
| blink_a | input | 1 | Blink waveform from counter A |
| blink_b | input | 1 | Blink waveform from counter B |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| irq_grp | output | 4 | Interrupt per group of eight lines |

## Verification
The bench builds the bank with its default group width of eight, so there are four groups and the full 32-line width. It sweeps a single-line edge event across every line, covering the cause bit, the group interrupt and the acknowledge for each one. It also walks one-hot patterns through the level path under two polarity settings, and runs all four blink-waveform combinations against mixed enable and select masks. These sweeps reach every group boundary and both counter selections. The same-cycle clear-versus-edge race and the polarity-flip edge are each driven at their exact cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int LINES  = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFF_OUT   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_BLINK = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_POL   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_IN    = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_EMSK  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_LMSK  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_BSEL  = 6'h20;

    typedef struct packed {
        logic [LINES-1:0] out_val;
        logic [LINES-1:0] dir_in;
        logic [LINES-1:0] blink_on;
        logic [LINES-1:0] invert;
        logic [LINES-1:0] edge_msk;
        logic [LINES-1:0] lvl_msk;
        logic [LINES-1:0] blink_sel;
    } bank_cfg_t;

    localparam bank_cfg_t CFG_RESET = '{
        out_val:   '0,
        dir_in:    '1,
        blink_on:  '0,
        invert:    '0,
        edge_msk:  '0,
        lvl_msk:   '0,
        blink_sel: '0
    };
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_d, meta_q, stab_d, stab_q;
    logic [1:0]   warm_d, warm_q;

    always_comb begin
        meta_d = d;
        stab_d = meta_q;
        warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            warm_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
            warm_q <= warm_d;
        end
    end

    assign q = stab_q;

    // R3: output equals the input two clocks earlier once both stages are filled
    assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic         clr_en,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] cause
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] cause_d, cause_q;
    logic [W-1:0] hit;

    always_comb begin
        hit     = level & ~prev_q;
        prev_d  = level;
        cause_d = clr_en ? (cause_q & clr_keep) : cause_q;
        cause_d = cause_d | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= prev_d;
            cause_q <= cause_d;
        end
    end

    assign cause = cause_q;

    // R5: without a clear write, no set bit can drop
    assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    // R6: an edge seen during a clear still leaves its bit set
    assert_edge_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (hit != '0)) |=> ((cause_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int W = 32,
    parameter int G = 8,
    localparam int NG = W / G
) (
    input  logic [W-1:0]  pending,
    output logic [NG-1:0] irq
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign irq[g] = |pending[g*G +: G];
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int GROUP_W = 8,
    localparam int NGRP = LINES / GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]  pin_in,
    input  logic              blink_a,
    input  logic              blink_b,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic [NGRP-1:0]   irq_grp
);
    bank_cfg_t        cfg_d, cfg_q;
    logic [LINES-1:0] sync_val;
    logic [LINES-1:0] adj_in;
    logic [LINES-1:0] cause;
    logic [LINES-1:0] pending;
    logic             cause_clr;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFF_OUT:   cfg_d.out_val   = reg_wdata;
                OFF_DIR:   cfg_d.dir_in    = reg_wdata;
                OFF_BLINK: cfg_d.blink_on  = reg_wdata;
                OFF_POL:   cfg_d.invert    = reg_wdata;
                OFF_EMSK:  cfg_d.edge_msk  = reg_wdata;
                OFF_LMSK:  cfg_d.lvl_msk   = reg_wdata;
                OFF_BSEL:  cfg_d.blink_sel = reg_wdata;
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    gpio_sync #(.W(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_val)
    );

    assign adj_in    = sync_val ^ cfg_q.invert;
    assign cause_clr = reg_wr && (reg_addr == OFF_CAUSE);

    gpio_edge_cause #(.W(LINES)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (adj_in),
        .clr_en   (cause_clr),
        .clr_keep (reg_wdata),
        .cause    (cause)
    );

    assign pending = (adj_in & cfg_q.lvl_msk) | (cause & cfg_q.edge_msk);

    gpio_irq_group #(.W(LINES), .G(GROUP_W)) u_group (
        .pending (pending),
        .irq     (irq_grp)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_pad
        logic wave;
        assign wave       = cfg_q.blink_sel[i] ? blink_b : blink_a;
        assign pin_out[i] = cfg_q.blink_on[i] ? wave : cfg_q.out_val[i];
        assign pin_oe[i]  = ~cfg_q.dir_in[i];
    end

    always_comb begin
        unique case (reg_addr)
            OFF_OUT:   reg_rdata = cfg_q.out_val;
            OFF_DIR:   reg_rdata = cfg_q.dir_in;
            OFF_BLINK: reg_rdata = cfg_q.blink_on;
            OFF_POL:   reg_rdata = cfg_q.invert;
            OFF_IN:    reg_rdata = adj_in;
            OFF_CAUSE: reg_rdata = cause;
            OFF_EMSK:  reg_rdata = cfg_q.edge_msk;
            OFF_LMSK:  reg_rdata = cfg_q.lvl_msk;
            OFF_BSEL:  reg_rdata = cfg_q.blink_sel;
            default:   reg_rdata = '0;
        endcase
    end

    // R8: with both masks cleared no group may signal
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lvl_msk == '0 && cfg_q.edge_msk == '0) |-> (irq_grp == '0));

    // R1: the cycle after reset all lines are inputs
    assert_reset_inputs_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = 0;
    logic        blink_a = 0, blink_b = 0;
    logic [31:0] pin_out, pin_oe;
    logic [3:0]  irq_grp;

    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_irq_bank u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .blink_a(blink_a), .blink_b(blink_b), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_grp(irq_grp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [3:0] grp(input logic [31:0] p);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |p[g*8 +: 8];
        return r;
    endfunction

    initial begin
        #2_000_000ns;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0] rw_offs [7];
        rw_offs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h18, 6'h1C, 6'h20};

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset values
        rd(6'h04, v); chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(6'h00, v); chk("R1 out", v, 0);
        rd(6'h14, v); chk("R1 cause", v, 0);
        rd(6'h1C, v); chk("R1 lmsk", v, 0);
        chk("R1 oe", pin_oe, 0);
        chk("R1 irq", {28'b0, irq_grp}, 0);

        // R10 read back of every writable register
        foreach (rw_offs[k]) begin
            logic [31:0] pat;
            pat = 32'h1234_5678 ^ (32'h0101_0101 * (k + 1));
            wr(rw_offs[k], pat);
            rd(rw_offs[k], v); chk("R10 readback", v, pat);
            wr(rw_offs[k], 32'hFFFF_FFFF);
            rd(rw_offs[k], v); chk("R10 readback ones", v, 32'hFFFF_FFFF);
        end
        // restore defaults
        wr(6'h00, 0); wr(6'h04, 32'hFFFF_FFFF); wr(6'h08, 0); wr(6'h0C, 0);
        wr(6'h18, 0); wr(6'h1C, 0); wr(6'h20, 0);
        settle();
        wr(6'h14, 0);

        // R3 input path, writes to data-in ignored
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, v); chk("R3 data-in write ignored", v, 0);
        for (int p = 0; p < 2; p++) begin
            logic [31:0] pol;
            pol = p ? 32'hF0F0_3C3C : 32'h0;
            wr(6'h0C, pol);
            for (int k = 0; k < 6; k++) begin
                pin_in = 32'h9E37_79B9 * (k + 1);
                @(negedge clk);
                rd(6'h10, v); chk("R3 one clock too early", v, pol);
                pin_in = pin_in; @(negedge clk);
                rd(6'h10, v); chk("R3 data-in", v, pin_in ^ pol);
                pin_in = 0; settle();
            end
        end
        wr(6'h0C, 0); settle(); wr(6'h14, 0);

        // R4/R5/R8 walk one edge over every line
        for (int i = 0; i < 32; i++) begin
            logic [31:0] b;
            b = 32'h1 << i;
            wr(6'h18, b);
            pin_in = b; settle();
            rd(6'h14, v); chk("R4 rising edge cause", v, b);
            chk("R8 edge group irq", {28'b0, irq_grp}, {28'b0, 4'b1 << (i / 8)});
            pin_in = 0; settle();
            rd(6'h14, v); chk("R5 cause held without write", v, b);
            wr(6'h14, ~b);
            rd(6'h14, v); chk("R5 ack clears", v, 0);
            chk("R8 irq after ack", {28'b0, irq_grp}, 0);
        end
        wr(6'h18, 0);

        // R5 write of ones keeps bits
        pin_in = 32'h0000_0081; settle();
        wr(6'h14, 32'hFFFF_FFFE);
        rd(6'h14, v); chk("R5 keep ones clear zero", v, 32'h0000_0080);
        pin_in = 0; wr(6'h14, 0); settle();

        // R4 polarity flip on steady low lines registers an edge
        wr(6'h0C, 32'hFFFF_FFFF); settle();
        rd(6'h14, v); chk("R4 polarity flip edge", v, 32'hFFFF_FFFF);
        wr(6'h14, 0);
        pin_in = 32'h20; settle();
        rd(6'h14, v); chk("R4 inverted rising pin no edge", v, 0);
        pin_in = 0; settle();
        rd(6'h14, v); chk("R4 inverted falling pin edge", v, 32'h20);
        wr(6'h0C, 0); settle(); wr(6'h14, 0);

        // R6 edge and clear in the same cycle
        pin_in = 32'h1; settle();
        pin_in = 32'h3;
        @(negedge clk);
        wr(6'h14, 0);
        rd(6'h14, v); chk("R6 edge wins over clear", v, 32'h2);
        pin_in = 0; settle(); wr(6'h14, 0);

        // R7/R8 live level sweep
        wr(6'h1C, 32'hFFFF_FFFF);
        for (int p = 0; p < 2; p++) begin
            logic [31:0] pol;
            pol = p ? 32'hFFFF_0000 : 32'h0;
            wr(6'h0C, pol);
            for (int i = 0; i < 32; i += 3) begin
                pin_in = 32'h1 << i; settle();
                chk("R7 level irq", {28'b0, irq_grp}, {28'b0, grp(pin_in ^ pol)});
            end
            pin_in = 0; settle();
            chk("R7 level follows input", {28'b0, irq_grp}, {28'b0, grp(pol)});
        end
        wr(6'h1C, 32'h0000_FF00); wr(6'h0C, 0); wr(6'h18, 0);
        settle(); wr(6'h14, 0);
        pin_in = 32'h0101_0101; settle();
        chk("R7 level mask selects", {28'b0, irq_grp}, 32'h2);
        pin_in = 0; settle();
        chk("R7 level not latched", {28'b0, irq_grp}, 0);
        wr(6'h1C, 0); wr(6'h14, 0);

        // R2 direction and output data
        wr(6'h00, 32'hA5A5_5A5A);
        wr(6'h04, 32'h0000_FFFF);
        chk("R2 oe", pin_oe, 32'hFFFF_0000);
        chk("R2 out data", pin_out, 32'hA5A5_5A5A);
        wr(6'h04, 0);
        chk("R2 all outputs", pin_oe, 32'hFFFF_FFFF);

        // R9 blink sweep
        wr(6'h08, 32'h0F0F_F0F0);
        wr(6'h20, 32'h3333_CCCC);
        for (int c = 0; c < 4; c++) begin
            logic [31:0] en, sel, wave, e;
            blink_a = c[0]; blink_b = c[1];
            en = 32'h0F0F_F0F0; sel = 32'h3333_CCCC;
            wave = (sel & {32{c[1]}}) | (~sel & {32{c[0]}});
            e = (~en & 32'hA5A5_5A5A) | (en & wave);
            #1 chk("R9 blink mux", pin_out, e);
            @(negedge clk);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule